// File: doc/BRIEF.md
# Start-up Delay Sequencer

This block keeps a chip's logic in reset, or keeps its clock gated, until the oscillator has had time to settle. Every delay is measured in oscillator cycles, plus a timeout that counts pulses on a separate slow tick input. The length is looked up from a 1-bit oscillator-type select (1 = crystal, 0 = ceramic resonator) and a 2-bit start-up code.

After a reset, from either the pin or a request, the sequencer first counts 14 oscillator cycles. It then waits a timeout of 0, 4 or 64 milliseconds, counted on the tick. Only then does it release the internal reset and raise ready. A wake-up request from sleep leaves the reset released and drops ready. Ready returns after a long count of oscillator cycles, whose length depends on the oscillator type.

Top module: `startup_delay_seq`

## Requirements
- R1: While `rst_ni` is low, `ready_o` and `rst_release_o` are both 0.
- R2: The cycle phase lasts exactly 14 rising clock edges. It starts after `rst_ni` rises, or after the last edge at which `rst_req_i` is high. When the selected timeout is 0 ms, `ready_o` and `rst_release_o` rise together on the 14th edge.
- R3: The timeout in milliseconds is looked up from {`osc_xtal_i`, `sut_code_i`}: 1/00 gives 64, 1/01 gives 0, 1/10 gives 4, 1/11 gives 64, 0/00 gives 4, 0/01 gives 64, 0/10 gives 0, 0/11 gives 4. A timeout of M ms ends on the edge that samples the (M × TICKS_PER_MS)-th `tick_i` pulse. Both outputs rise on that edge.
- R4: `tick_i` pulses seen during the cycle phase are not counted. This includes the edge that ends the cycle phase.
- R5: The select fields are sampled on the edge that ends the cycle phase. Changing them during the timeout phase does not change its length.
- R6: `rst_req_i` high at an edge forces both outputs to 0 after that edge and restarts the sequence from the cycle phase. This holds in every phase, and the request wins over `wake_req_i` at the same edge. `rst_release_o` falls only as a result of such a request.
- R7: Once ready, `ready_o` and `rst_release_o` stay high until `rst_req_i` or `wake_req_i` is seen.
- R8: `wake_req_i` at an edge while ready drops `ready_o` after that edge and keeps `rst_release_o` high. `ready_o` rises again on the 16384th edge after the request edge when `osc_xtal_i` is 1 at the request, and on the 1024th when it is 0.
- R9: `wake_req_i` is ignored during the reset sequence and while a wake-up count is already running.
- R10: `ready_o` is never high while `rst_release_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Slow timebase pulse, one clock wide, TICKS_PER_MS per millisecond |
| osc_xtal_i | input | 1 | Oscillator type: 1 crystal, 0 ceramic resonator |
| sut_code_i | input | 2 | Start-up code |
| rst_req_i | input | 1 | Reset request, restarts the sequence |
| wake_req_i | input | 1 | Wake-from-sleep request |
| ready_o | output | 1 | Clock is stable and may be used |
| rst_release_o | output | 1 | Internal reset released |

## Verification
Every output is decoded directly from the state register. A result therefore shows after the edge that ends a count: the 14th edge after a reset, the edge that samples the last counted tick, or the 16384th or 1024th edge after a wake request. The bench drives inputs on falling edges and drives each tick as a single-cycle pulse. It counts edges from the request edge, then samples on the falling edge one short of the expected count, where the output must still be low. It samples again one edge later, where the output must be high. This pins each delay to the exact cycle, so an off-by-one in either direction fails.

// File: rtl/startup_delay_pkg.sv
package startup_delay_pkg;

  typedef enum logic [1:0] {
    ST_CYC  = 2'd0,
    ST_MS   = 2'd1,
    ST_RUN  = 2'd2,
    ST_WAKE = 2'd3
  } sdly_state_e;

  typedef enum logic [1:0] {
    MS_NONE  = 2'd0,
    MS_SHORT = 2'd1,
    MS_LONG  = 2'd2
  } ms_sel_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/startup_delay_decode.sv
module startup_delay_decode
  import startup_delay_pkg::*;
#(
  parameter int TICKS_PER_MS = 8,
  parameter int SHORT_MS     = 4,
  parameter int LONG_MS      = 64,
  parameter int WAKE_XTAL    = 16384,
  parameter int WAKE_RES     = 1024,
  parameter int CNT_W        = 15
) (
  input  logic             osc_xtal_i,
  input  logic [1:0]       sut_code_i,
  output logic [CNT_W-1:0] ms_ticks_o,
  output logic             ms_zero_o,
  output logic [CNT_W-1:0] wake_cyc_o
);

  localparam int SHORT_TICKS = SHORT_MS * TICKS_PER_MS;
  localparam int LONG_TICKS  = LONG_MS * TICKS_PER_MS;

  ms_sel_e ms_sel;

  always_comb begin
    unique case ({osc_xtal_i, sut_code_i})
      3'b1_00: ms_sel = MS_LONG;
      3'b1_01: ms_sel = MS_NONE;
      3'b1_10: ms_sel = MS_SHORT;
      3'b1_11: ms_sel = MS_LONG;
      3'b0_00: ms_sel = MS_SHORT;
      3'b0_01: ms_sel = MS_LONG;
      3'b0_10: ms_sel = MS_NONE;
      default: ms_sel = MS_SHORT;
    endcase
  end

  always_comb begin
    unique case (ms_sel)
      MS_SHORT: ms_ticks_o = CNT_W'(SHORT_TICKS);
      MS_LONG:  ms_ticks_o = CNT_W'(LONG_TICKS);
      default:  ms_ticks_o = '0;
    endcase
  end

  assign ms_zero_o  = (ms_sel == MS_NONE);
  assign wake_cyc_o = osc_xtal_i ? CNT_W'(WAKE_XTAL) : CNT_W'(WAKE_RES);

endmodule

// File: rtl/startup_delay_counter.sv
module startup_delay_counter #(
  parameter int CNT_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] tgt_i,
  output logic             hit_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (en_i)  cnt_q <= cnt_q + CNT_W'(1);
  end

  // last count of the window; caller qualifies with its enable
  assign hit_o = (cnt_q == tgt_i - CNT_W'(1));

endmodule

// File: rtl/startup_delay_seq.sv
module startup_delay_seq
  import startup_delay_pkg::*;
#(
  parameter int RST_CYC      = 14,
  parameter int TICKS_PER_MS = 8,
  parameter int SHORT_MS     = 4,
  parameter int LONG_MS      = 64,
  parameter int WAKE_XTAL    = 16384,
  parameter int WAKE_RES     = 1024
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       osc_xtal_i,
  input  logic [1:0] sut_code_i,
  input  logic       rst_req_i,
  input  logic       wake_req_i,
  output logic       ready_o,
  output logic       rst_release_o
);

  localparam int MAX_CNT = max2(max2(WAKE_XTAL, WAKE_RES),
                                max2(LONG_MS * TICKS_PER_MS, RST_CYC));
  localparam int CNT_W   = $clog2(MAX_CNT + 1);

  sdly_state_e      state_q, state_d;
  logic [CNT_W-1:0] tgt_q, tgt_d, cnt_tgt;
  logic [CNT_W-1:0] ms_ticks, wake_cyc;
  logic             ms_zero;
  logic             cnt_clr, cnt_en, cnt_hit;

  startup_delay_decode #(
    .TICKS_PER_MS(TICKS_PER_MS),
    .SHORT_MS    (SHORT_MS),
    .LONG_MS     (LONG_MS),
    .WAKE_XTAL   (WAKE_XTAL),
    .WAKE_RES    (WAKE_RES),
    .CNT_W       (CNT_W)
  ) u_decode (
    .osc_xtal_i(osc_xtal_i),
    .sut_code_i(sut_code_i),
    .ms_ticks_o(ms_ticks),
    .ms_zero_o (ms_zero),
    .wake_cyc_o(wake_cyc)
  );

  startup_delay_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cnt_clr),
    .en_i  (cnt_en),
    .tgt_i (cnt_tgt),
    .hit_o (cnt_hit)
  );

  always_comb begin
    state_d = state_q;
    tgt_d   = tgt_q;
    cnt_clr = 1'b0;
    cnt_en  = 1'b0;
    cnt_tgt = tgt_q;
    unique case (state_q)
      ST_CYC: begin
        cnt_tgt = CNT_W'(RST_CYC);
        cnt_en  = 1'b1;
        if (cnt_hit) begin
          cnt_clr = 1'b1;
          tgt_d   = ms_ticks;  // select fields frozen here
          state_d = ms_zero ? ST_RUN : ST_MS;
        end
      end
      ST_MS: begin
        cnt_en = tick_i;
        if (tick_i && cnt_hit) begin
          cnt_clr = 1'b1;
          state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        if (wake_req_i) begin
          cnt_clr = 1'b1;
          tgt_d   = wake_cyc;
          state_d = ST_WAKE;
        end
      end
      ST_WAKE: begin
        cnt_en = 1'b1;
        if (cnt_hit) begin
          cnt_clr = 1'b1;
          state_d = ST_RUN;
        end
      end
      default: state_d = ST_CYC;
    endcase
    if (rst_req_i) begin
      cnt_clr = 1'b1;
      state_d = ST_CYC;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_CYC;
      tgt_q   <= '0;
    end else begin
      state_q <= state_d;
      tgt_q   <= tgt_d;
    end
  end

  assign ready_o       = (state_q == ST_RUN);
  assign rst_release_o = (state_q == ST_RUN) || (state_q == ST_WAKE);

endmodule

// File: rtl/startup_delay_chk.sv
module startup_delay_chk #(
  parameter int RST_CYC = 14
) (
  input logic clk_i,
  input logic rst_ni,
  input logic rst_req_i,
  input logic wake_req_i,
  input logic ready_o,
  input logic rst_release_o
);

  localparam int LW = $clog2(RST_CYC + 1) + 1;

  logic [LW-1:0] low_cnt;

  // edges spent with the reset held since the last request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       low_cnt <= '0;
    else if (rst_req_i || rst_release_o) low_cnt <= '0;
    else if (low_cnt != '1)            low_cnt <= low_cnt + LW'(1);
  end

  assert_ready_needs_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> rst_release_o);

  assert_req_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_i |=> (!ready_o && !rst_release_o));

  assert_release_falls_on_req_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_release_o) |-> $past(rst_req_i));

  assert_ready_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !rst_req_i && !wake_req_i) |=> ready_o);

  assert_wake_gates_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && wake_req_i && !rst_req_i) |=> (!ready_o && rst_release_o));

  assert_cycle_phase_min_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_release_o) |-> (low_cnt >= LW'(RST_CYC)));

  always_comb begin
    if (!rst_ni) assert_reset_low_R1: assert (!ready_o && !rst_release_o);
  end

endmodule

bind startup_delay_seq startup_delay_chk #(.RST_CYC(RST_CYC)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rst_req_i    (rst_req_i),
  .wake_req_i   (wake_req_i),
  .ready_o      (ready_o),
  .rst_release_o(rst_release_o)
);

// File: tb/startup_delay_seq_bench.sv
`timescale 1ns/1ps
module startup_delay_seq_bench;

  localparam int TPM = 8;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       osc_xtal_i = 1'b1;
  logic [1:0] sut_code_i = 2'b01;
  logic       rst_req_i = 1'b0;
  logic       wake_req_i = 1'b0;
  logic       ready_o, rst_release_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk_i = ~clk_i;

  startup_delay_seq u_startup_delay_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .osc_xtal_i   (osc_xtal_i),
    .sut_code_i   (sut_code_i),
    .rst_req_i    (rst_req_i),
    .wake_req_i   (wake_req_i),
    .ready_o      (ready_o),
    .rst_release_o(rst_release_o)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic tick_pulse(input int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1'b1; cyc(1);
      tick_i = 1'b0; cyc(1);
    end
  endtask

  task automatic req_pulse();
    rst_req_i = 1'b1; cyc(1);
    rst_req_i = 1'b0;
    chk("R6", "ready after request", ready_o, 1'b0);
    chk("R6", "release after request", rst_release_o, 1'b0);
  endtask

  task automatic t_reset_state();
    rst_ni = 1'b0;
    tick_i = 1'b1;
    cyc(4);
    chk("R1", "ready in reset", ready_o, 1'b0);
    chk("R1", "release in reset", rst_release_o, 1'b0);
    tick_i = 1'b0;
  endtask

  task automatic t_power_on();
    osc_xtal_i = 1'b1; sut_code_i = 2'b01;
    cyc(1);
    rst_ni = 1'b1;
    cyc(13);
    chk("R2", "ready after 13 edges", ready_o, 1'b0);
    cyc(1);
    chk("R2", "ready after 14 edges", ready_o, 1'b1);
    chk("R2", "release after 14 edges", rst_release_o, 1'b1);
    cyc(40);
    chk("R7", "ready held", ready_o, 1'b1);
  endtask

  // reset request then full sequence; ticks held high through the cycle phase
  task automatic t_req_ms(input logic sel, input logic [1:0] sut, input int ms, input logic mid_change);
    osc_xtal_i = sel; sut_code_i = sut;
    req_pulse();
    tick_i = 1'b1;
    cyc(13);
    chk("R4", "ready during cycle phase", ready_o, 1'b0);
    cyc(1);
    tick_i = 1'b0;
    if (ms == 0) begin
      chk("R3", "zero-ms ready", ready_o, 1'b1);
      chk("R2", "zero-ms release", rst_release_o, 1'b1);
    end else begin
      chk("R4", "ready at timeout start", ready_o, 1'b0);
      if (mid_change) begin
        sut_code_i = ~sut;
        osc_xtal_i = ~sel;
      end
      tick_pulse(ms * TPM - 1);
      chk(mid_change ? "R5" : "R3", "ready one tick early", ready_o, 1'b0);
      chk("R3", "release one tick early", rst_release_o, 1'b0);
      tick_pulse(1);
      chk(mid_change ? "R5" : "R3", "ready at last tick", ready_o, 1'b1);
      chk("R3", "release at last tick", rst_release_o, 1'b1);
      osc_xtal_i = sel; sut_code_i = sut;
    end
  endtask

  task automatic t_abort_mid_ms();
    osc_xtal_i = 1'b1; sut_code_i = 2'b11;
    req_pulse();
    cyc(14);
    tick_pulse(100);
    chk("R6", "ready mid timeout", ready_o, 1'b0);
    t_req_ms(1'b1, 2'b11, 64, 1'b0);
  endtask

  task automatic t_wake(input logic sel, input int n);
    osc_xtal_i = sel;
    wake_req_i = 1'b1; cyc(1);
    wake_req_i = 1'b0;
    chk("R8", "ready after wake request", ready_o, 1'b0);
    chk("R8", "release kept on wake", rst_release_o, 1'b1);
    cyc(n - 1);
    chk("R8", "ready one edge early", ready_o, 1'b0);
    chk("R8", "release during wake", rst_release_o, 1'b1);
    cyc(1);
    chk("R8", "ready at wake end", ready_o, 1'b1);
  endtask

  task automatic t_wake_ignored();
    // wake during reset sequence
    osc_xtal_i = 1'b1; sut_code_i = 2'b01;
    req_pulse();
    wake_req_i = 1'b1;
    cyc(13);
    chk("R9", "ready with wake in reset", ready_o, 1'b0);
    cyc(1);
    wake_req_i = 1'b0;
    chk("R9", "ready after reset despite wake", ready_o, 1'b1);
    // second wake during running wake count
    osc_xtal_i = 1'b0;
    wake_req_i = 1'b1; cyc(1);
    wake_req_i = 1'b0;
    cyc(499);
    wake_req_i = 1'b1; cyc(1);
    wake_req_i = 1'b0;
    cyc(523);
    chk("R9", "ready one edge early", ready_o, 1'b0);
    cyc(1);
    chk("R9", "ready not restarted", ready_o, 1'b1);
  endtask

  task automatic t_req_in_wake();
    osc_xtal_i = 1'b1; sut_code_i = 2'b01;
    wake_req_i = 1'b1; cyc(1);
    wake_req_i = 1'b0;
    cyc(100);
    req_pulse();
    cyc(13);
    chk("R6", "ready early after abort", ready_o, 1'b0);
    cyc(1);
    chk("R6", "ready after restart", ready_o, 1'b1);
    // request and wake together
    rst_req_i = 1'b1; wake_req_i = 1'b1; cyc(1);
    rst_req_i = 1'b0; wake_req_i = 1'b0;
    chk("R6", "release with both requests", rst_release_o, 1'b0);
    chk("R10", "ready with release low", ready_o, 1'b0);
    cyc(14);
    chk("R6", "ready after priority restart", ready_o, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset_state();
    t_power_on();
    t_req_ms(1'b1, 2'b01, 0, 1'b0);
    t_req_ms(1'b1, 2'b10, 4, 1'b0);
    t_req_ms(1'b1, 2'b11, 64, 1'b0);
    t_req_ms(1'b1, 2'b00, 64, 1'b0);
    t_req_ms(1'b0, 2'b11, 4, 1'b0);
    t_req_ms(1'b0, 2'b00, 4, 1'b0);
    t_req_ms(1'b0, 2'b01, 64, 1'b0);
    t_req_ms(1'b0, 2'b10, 0, 1'b0);
    t_req_ms(1'b1, 2'b10, 4, 1'b1);
    t_abort_mid_ms();
    t_wake(1'b1, 16384);
    t_wake(1'b0, 1024);
    t_wake_ignored();
    t_req_in_wake();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule